// File: doc/BRIEF.md
# PLL control and lock sequencer

This block is the digital control side of a clock multiplier. Software reaches an 8-bit control byte through a small write bus. A write can replace the whole byte, or it can change a single bit chosen by index. The byte holds five things: the enable for the analog loop, the multiply and divide selections, an output-range flag, and a request to run the core from the multiplied clock. It also holds a lock-wait code, which sets how long to wait after the loop is turned on. All of these go straight to the analog and divider logic outside the block.

When the enable bit is stored, a counter clocked by the main clock starts. The lock flag rises when the selected number of cycles has passed. The request to run from the multiplied clock is accepted only while locked. A separate status bit drives the external clock multiplexer, and it follows that request only while lock holds and no clock stop is reported. An external monitor can report a stopped clock. The report drops the status bit but leaves the request bit in the control byte unchanged, so software can see what it asked for. A global write-protect input freezes the byte.

Top module: `pll_ctrl_seq`

## Requirements
- R1: After reset the control byte reads 0x00 and lock_o and mode_sts_o are 0.
- R2: A byte write (wr_bit_i=0) stores wr_data_i into the control byte. Bit 3 always reads 0. The fields are: bits 7:6 wait code, bit 5 range, bit 4 divide, bit 2 mode request, bit 1 multiply, bit 0 enable.
- R3: A bit write (wr_bit_i=1) sets bit wr_idx_i to wr_data_i[0] and leaves every other bit unchanged. A bit write to index 3 has no effect.
- R4: While wprot_i is 1, no write changes the control byte.
- R5: A write while lock_o is 0 leaves bit 2 unchanged. The other bits of the same byte write still take effect.
- R6: lock_o rises exactly N main-clock cycles after the cycle in which the enable bit is first seen stored. N is BASE_WAIT for wait code 00, 2*BASE_WAIT for code 01 and 4*BASE_WAIT for code 10.
- R7: Wait code 11 is stored and read back as 11, and it waits 4*BASE_WAIT cycles.
- R8: Changing the wait code while a count runs does not change when that count ends.
- R9: Clearing the enable bit drops lock_o and mode_sts_o in the same cycle the bit reads 0. A later enable waits the full count again.
- R10: mode_sts_o equals bit 2 of the previous cycle whenever lock_o was 1 and clk_stop_i was 0 in the previous cycle, and the enable bit is still 1. mode_sts_o is never 1 without lock_o.
- R11: One cycle after clk_stop_i is seen at 1, mode_sts_o is 0, and bit 2 of the control byte keeps its value.
- R12: pll_en_o, mul_sel_o, div_sel_o and range_sel_o equal control bits 0, 1, 4 and 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Write strobe |
| wr_bit_i | input | 1 | 1: single-bit write, 0: byte write |
| wr_idx_i | input | 3 | Bit index for single-bit writes |
| wr_data_i | input | 8 | Write byte; bit 0 is the value for bit writes |
| wprot_i | input | 1 | Global write protect |
| clk_stop_i | input | 1 | Clock-stop report from external monitor |
| ctrl_o | output | 8 | Control byte read-back |
| pll_en_o | output | 1 | Analog loop enable |
| mul_sel_o | output | 1 | Multiply select (0: x12, 1: x16) |
| div_sel_o | output | 1 | Divide select (0: /2, 1: /4) |
| range_sel_o | output | 1 | Output-range select |
| lock_o | output | 1 | Lock status |
| mode_sts_o | output | 1 | Multiplied-clock mode status, drives external mux |

## Verification
The bench builds the block with BASE_WAIT=8, so the waits are 8, 16 and 32 cycles instead of 128 to 512. With waits this short, all four wait codes, a relock after disable and a wait-code change during a count fit into the directed part. The short waits also let the random phase go through hundreds of lock, unlock and clock-stop episodes. In each of those episodes, the mode-request gating and the status lag are compared cycle by cycle with a behavioural model.

// File: rtl/pll_ctrl_pkg.sv
package pll_ctrl_pkg;
  localparam int unsigned CTRL_W    = 8;
  localparam int unsigned IDX_EN    = 0;
  localparam int unsigned IDX_MUL   = 1;
  localparam int unsigned IDX_MODE  = 2;
  localparam int unsigned IDX_RSVD  = 3;
  localparam int unsigned IDX_DIV   = 4;
  localparam int unsigned IDX_RNG   = 5;
  localparam int unsigned IDX_WAIT  = 6;

  typedef enum logic [1:0] {
    WAIT_X1  = 2'b00,
    WAIT_X2  = 2'b01,
    WAIT_X4  = 2'b10,
    WAIT_BAD = 2'b11
  } wait_code_e;
endpackage

// File: rtl/pll_ctrl_reg.sv
module pll_ctrl_reg
  import pll_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_bit_i,
  input  logic [2:0]        wr_idx_i,
  input  logic [CTRL_W-1:0] wr_data_i,
  input  logic              wprot_i,
  input  logic              lock_i,
  output logic [CTRL_W-1:0] ctrl_o
);
  logic [CTRL_W-1:0] ctrl_q, ctrl_d, wr_val;

  always_comb begin
    wr_val = ctrl_q;
    if (wr_bit_i) wr_val[wr_idx_i] = wr_data_i[0];
    else          wr_val = wr_data_i;
    wr_val[IDX_RSVD] = 1'b0;
    // mode request accepted only with a stable loop
    if (!lock_i) wr_val[IDX_MODE] = ctrl_q[IDX_MODE];
    ctrl_d = (wr_en_i && !wprot_i) ? wr_val : ctrl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ctrl_q <= '0;
    else         ctrl_q <= ctrl_d;
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/pll_lock_cnt.sv
module pll_lock_cnt
  import pll_ctrl_pkg::*;
#(
  parameter int unsigned BASE_WAIT = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic [1:0] code_i,
  output logic       lock_o
);
  localparam int unsigned MAX_WAIT = BASE_WAIT * 4;
  localparam int unsigned CNT_W    = $clog2(MAX_WAIT + 1);

  logic [CNT_W-1:0] cnt_q, lim_m1;
  logic             lock_q, started_q;
  wait_code_e       code_q, code_eff;

  // code is frozen at the first counting edge
  assign code_eff = started_q ? code_q : wait_code_e'(code_i);

  always_comb begin
    unique case (code_eff)
      WAIT_X1: lim_m1 = CNT_W'(BASE_WAIT - 1);
      WAIT_X2: lim_m1 = CNT_W'(2 * BASE_WAIT - 1);
      default: lim_m1 = CNT_W'(MAX_WAIT - 1);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      lock_q    <= 1'b0;
      started_q <= 1'b0;
      code_q    <= WAIT_X1;
    end else if (!en_i) begin
      cnt_q     <= '0;
      lock_q    <= 1'b0;
      started_q <= 1'b0;
    end else begin
      if (!started_q) begin
        started_q <= 1'b1;
        code_q    <= code_eff;
      end
      if (!lock_q) begin
        if (cnt_q == lim_m1) lock_q <= 1'b1;
        else                 cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign lock_o = lock_q & en_i;
endmodule

// File: rtl/pll_mode_sts.sv
module pll_mode_sts (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic mode_req_i,
  input  logic lock_i,
  input  logic clk_stop_i,
  output logic mode_sts_o
);
  logic sts_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sts_q <= 1'b0;
    else         sts_q <= mode_req_i & lock_i & ~clk_stop_i;
  end

  assign mode_sts_o = sts_q & en_i;
endmodule

// File: rtl/pll_ctrl_seq.sv
module pll_ctrl_seq
  import pll_ctrl_pkg::*;
#(
  parameter int unsigned BASE_WAIT = 128
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_en_i,
  input  logic       wr_bit_i,
  input  logic [2:0] wr_idx_i,
  input  logic [7:0] wr_data_i,
  input  logic       wprot_i,
  input  logic       clk_stop_i,
  output logic [7:0] ctrl_o,
  output logic       pll_en_o,
  output logic       mul_sel_o,
  output logic       div_sel_o,
  output logic       range_sel_o,
  output logic       lock_o,
  output logic       mode_sts_o
);
  logic [CTRL_W-1:0] ctrl;
  logic              lock;

  pll_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_bit_i  (wr_bit_i),
    .wr_idx_i  (wr_idx_i),
    .wr_data_i (wr_data_i),
    .wprot_i   (wprot_i),
    .lock_i    (lock),
    .ctrl_o    (ctrl)
  );

  pll_lock_cnt #(.BASE_WAIT(BASE_WAIT)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (ctrl[IDX_EN]),
    .code_i (ctrl[IDX_WAIT +: 2]),
    .lock_o (lock)
  );

  pll_mode_sts u_sts (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (ctrl[IDX_EN]),
    .mode_req_i (ctrl[IDX_MODE]),
    .lock_i     (lock),
    .clk_stop_i (clk_stop_i),
    .mode_sts_o (mode_sts_o)
  );

  assign ctrl_o      = ctrl;
  assign pll_en_o    = ctrl[IDX_EN];
  assign mul_sel_o   = ctrl[IDX_MUL];
  assign div_sel_o   = ctrl[IDX_DIV];
  assign range_sel_o = ctrl[IDX_RNG];
  assign lock_o      = lock;
endmodule

// File: rtl/pll_ctrl_seq_chk.sv
module pll_ctrl_seq_chk #(
  parameter int unsigned BASE_WAIT = 128
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wprot_i,
  input logic       clk_stop_i,
  input logic [7:0] ctrl_o,
  input logic       pll_en_o,
  input logic       lock_o,
  input logic       mode_sts_o
);
  int unsigned en_age;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        en_age <= 0;
    else if (!pll_en_o) en_age <= 0;
    else if (en_age < 32'hFFFF) en_age <= en_age + 1;
  end

  assert_lock_min_wait_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lock_o) |-> en_age >= BASE_WAIT);

  assert_lock_needs_en_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_o |-> pll_en_o);

  assert_sts_needs_lock_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_sts_o |-> lock_o);

  assert_sts_follow_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lock_o && !clk_stop_i) |=> (mode_sts_o == ($past(ctrl_o[2]) && pll_en_o)));

  assert_wprot_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wprot_i |=> $stable(ctrl_o));

  assert_mode_gate_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |=> (ctrl_o[2] == $past(ctrl_o[2])));

  assert_stop_clears_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_stop_i |=> !mode_sts_o);
endmodule

bind pll_ctrl_seq pll_ctrl_seq_chk #(.BASE_WAIT(BASE_WAIT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wprot_i    (wprot_i),
  .clk_stop_i (clk_stop_i),
  .ctrl_o     (ctrl_o),
  .pll_en_o   (pll_en_o),
  .lock_o     (lock_o),
  .mode_sts_o (mode_sts_o)
);

// File: tb/pll_ctrl_seq_tb_top.sv
module pll_ctrl_seq_tb_top;
  localparam int unsigned BW = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0, wr_bit = 1'b0, wprot = 1'b0, clk_stop = 1'b0;
  logic [2:0] wr_idx = '0;
  logic [7:0] wr_data = '0;
  logic [7:0] ctrl;
  logic       pll_en, mul_sel, div_sel, range_sel, lock, mode_sts;

  int unsigned n_run = 0, n_fail = 0, cyc = 0;
  bit          model_on = 1'b0, done = 1'b0;

  always #5 clk = ~clk;

  pll_ctrl_seq #(.BASE_WAIT(BW)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_bit_i(wr_bit),
    .wr_idx_i(wr_idx), .wr_data_i(wr_data), .wprot_i(wprot),
    .clk_stop_i(clk_stop), .ctrl_o(ctrl), .pll_en_o(pll_en),
    .mul_sel_o(mul_sel), .div_sel_o(div_sel), .range_sel_o(range_sel),
    .lock_o(lock), .mode_sts_o(mode_sts)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic int unsigned wait_len(logic [1:0] c);
    case (c)
      2'b00:   return BW;
      2'b01:   return 2 * BW;
      default: return 4 * BW;
    endcase
  endfunction

  function automatic logic [7:0] apply_wr(logic [7:0] cur, logic b, logic [2:0] i,
                                         logic [7:0] d, logic lk);
    logic [7:0] n;
    n = cur;
    if (b) n[i] = d[0];
    else   n = d;
    n[3] = 1'b0;
    if (!lk) n[2] = cur[2];
    return n;
  endfunction

  // reference model
  logic [7:0]  m_ctrl;
  int unsigned m_age, m_tgt;
  logic        m_sts;
  wire m_lock = m_ctrl[0] && (m_age != 0) && (m_age >= m_tgt);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl <= '0; m_age <= 0; m_tgt <= 0; m_sts <= 1'b0;
    end else begin
      if (!m_ctrl[0]) m_age <= 0;
      else if (m_age < 4096) m_age <= m_age + 1;
      if (m_ctrl[0] && m_age == 0) m_tgt <= wait_len(m_ctrl[7:6]);
      m_sts <= m_ctrl[2] && m_lock && !clk_stop;
      if (wr_en && !wprot) m_ctrl <= apply_wr(m_ctrl, wr_bit, wr_idx, wr_data, m_lock);
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk("R2 model ctrl", ctrl, m_ctrl);
      chk("R6 model lock", lock, m_lock);
      chk("R10 model sts", mode_sts, m_sts && m_ctrl[0]);
      chk("R12 model mirror", {range_sel, div_sel, mul_sel, pll_en},
          {m_ctrl[5], m_ctrl[4], m_ctrl[1], m_ctrl[0]});
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !done) begin
      n_fail++;
      $display("FAIL R6 watchdog expired act=%0d exp<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  // each task starts and ends at a negedge
  task automatic byte_wr(logic [7:0] d);
    wr_en = 1'b1; wr_bit = 1'b0; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bit_wr(logic [2:0] i, logic v);
    wr_en = 1'b1; wr_bit = 1'b1; wr_idx = i; wr_data = {7'b0, v};
    @(negedge clk);
    wr_en = 1'b0; wr_bit = 1'b0;
  endtask

  task automatic measure(logic [7:0] d, int unsigned exp, string tag);
    int unsigned n = 0;
    byte_wr(d);
    while (!lock && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(tag, n, exp);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    chk("R1 reset ctrl", ctrl, 8'h00);
    chk("R1 reset lock/sts", {lock, mode_sts}, 2'b00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", {ctrl, lock, mode_sts}, 10'h000);

    // R2/R5: all-ones byte while unlocked
    byte_wr(8'hFF);
    chk("R2 R5 byte write unlocked", ctrl, 8'hF3);
    chk("R12 mirrors", {range_sel, div_sel, mul_sel, pll_en}, 4'hF);
    byte_wr(8'h00);

    // R6/R7: latency per wait code
    for (int c = 0; c < 4; c++) begin
      measure({c[1:0], 6'h01}, wait_len(c[1:0]), c == 3 ? "R7 wait code 11" : "R6 wait code");
      if (c == 3) chk("R7 code 11 stored", ctrl[7:6], 2'b11);
      byte_wr(8'h00);
    end

    // R8: change code mid-count
    byte_wr(8'h01);
    bit_wr(3'd7, 1'b1);
    repeat (6) @(negedge clk);
    chk("R8 not locked early", lock, 1'b0);
    @(negedge clk);
    chk("R8 lock at original count", lock, 1'b1);
    chk("R8 new code stored", ctrl[7:6], 2'b10);

    // R5/R10: mode request while locked
    byte_wr(8'h85);
    chk("R5 mode write accepted when locked", ctrl, 8'h85);
    chk("R10 status lags", mode_sts, 1'b0);
    @(negedge clk);
    chk("R10 status follows", mode_sts, 1'b1);

    // R11: clock stop
    clk_stop = 1'b1;
    @(negedge clk);
    chk("R11 status cleared", mode_sts, 1'b0);
    chk("R11 request kept", ctrl[2], 1'b1);
    clk_stop = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R10 status returns", mode_sts, 1'b1);

    // R4: write protect
    wprot = 1'b1;
    byte_wr(8'h00);
    bit_wr(3'd0, 1'b0);
    chk("R4 protected", ctrl, 8'h85);
    chk("R4 still locked", lock, 1'b1);
    wprot = 1'b0;

    // R3: bit writes
    bit_wr(3'd1, 1'b1);
    chk("R3 bit1 set", ctrl, 8'h87);
    bit_wr(3'd3, 1'b1);
    chk("R3 bit3 ignored", ctrl, 8'h87);
    bit_wr(3'd4, 1'b1);
    chk("R3 bit4 set", ctrl, 8'h97);
    chk("R12 mul/div", {div_sel, mul_sel}, 2'b11);

    // R9: disable drops lock and status at once
    bit_wr(3'd0, 1'b0);
    chk("R9 lock drops", lock, 1'b0);
    chk("R9 status drops", mode_sts, 1'b0);
    bit_wr(3'd2, 1'b0);
    chk("R5 mode clear ignored unlocked", ctrl[2], 1'b1);
    measure(8'h97, 4 * BW, "R9 full relock");
    @(negedge clk);
    chk("R10 status after relock", mode_sts, 1'b1);

    // random phase
    model_on = 1'b1;
    for (int i = 0; i < 4000; i++) begin
      wr_en    = ($urandom % 16) == 0;
      wr_bit   = $urandom % 2;
      wr_idx   = 3'($urandom);
      wr_data  = 8'($urandom);
      if (($urandom % 8) != 0) wr_data[0] = 1'b1;
      wprot    = ($urandom % 10) == 0;
      clk_stop = ($urandom % 20) == 0;
      @(negedge clk);
    end
    wr_en = 1'b0; wprot = 1'b0; clk_stop = 1'b0;
    @(negedge clk);
    model_on = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule